// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down on a slow low-speed tick and asks for a system reset when software stops servicing it. The tick arrives as a one-cycle enable pulse in the system clock domain. Each tick advances a prescaler whose length is picked by a 3-bit code. Every time the prescaler wraps, a 12-bit down-counter takes one step. When a step finds the counter already at zero, the block raises a one-cycle reset request and reloads the counter.

Software reaches the block only through a small register port that can write and read. Starting the watchdog, servicing it and opening the configuration registers are all done by writing magic values to a key register. The prescaler and reload registers take writes only after the unlock value has been written. A newly written prescaler or reload value becomes active only after a fixed number of low-speed ticks. During that interval a busy flag shows in the status register. A debug-freeze input holds the count while a debugger has the processor stopped. Once started, the watchdog keeps running until a system reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the block is idle and `reset_req` is low. The prescaler register reads 0, the reload register reads 0xFFF and the status register reads 0. While idle, ticks never produce a reset request.
- R2: Writing 0xCCCC to the key address (0) starts the watchdog and loads the counter. `reset_req` goes high in the cycle after the tick that ends (reload+1) × divider ticks, counted from the key write.
- R3: Writing 0xAAAA to the key address reloads the counter from the active reload value and clears the prescaler phase. A full timeout then starts again.
- R4: Writing 0x5555 to the key address unlocks the configuration registers. The prescaler register is at address 1, using bits [2:0]. The reload register is at address 2, using bits [11:0]. Writes to either address while locked are ignored, and the register reads back its old value.
- R5: Any key write other than 0x5555 locks the configuration registers again.
- R6: Prescaler codes 0 to 6 divide by 4, 8, 16, 32, 64, 128 and 256. Code 7 also divides by 256.
- R7: The status register is at address 3. Bit 0 is prescaler-busy and bit 1 is reload-busy. An accepted write sets the matching bit, and the bit clears after 2 ticks. The counter keeps using the old value until the bit clears.
- R8: While `dbg_freeze` is high, ticks do not advance the prescaler or the counter. Counting resumes from the same place when it goes low.
- R9: `reset_req` is high for exactly one cycle. The counter then restarts from the active reload value and keeps running.
- R10: Software cannot stop a running watchdog. No key write returns it to idle; only `rst` does.
- R11: When a refresh key write falls in the same cycle as the tick that would expire the counter, the refresh wins. No reset request is made and a full timeout starts again.
- R12: Read data is registered. `bus_rdata` shows the addressed register in the cycle after `bus_rd`, and the key address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lsi_tick | input | 1 | One-cycle pulse per low-speed clock period |
| dbg_freeze | input | 1 | Hold counting while high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
Two events can fall in the same cycle: the refresh path and the expiry step. The bench provokes this by putting a 0xAAAA key write in the same cycle as the tick that would end the countdown. The check passes only if no reset pulse follows and a whole new timeout is then measured. Configuration writes are also made while the counter is running and the busy countdown is active. The bench then checks that the running countdown still ends at the old length and that the next period uses the new value.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    ADDR_KEY  = 2'd0,
    ADDR_PRE  = 2'd1,
    ADDR_RLD  = 2'd2,
    ADDR_STAT = 2'd3
  } wdg_addr_e;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_RUN    = 16'hCCCC;
  localparam logic [KEY_W-1:0] KEY_KICK   = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_UNLOCK = 16'h5555;
endpackage

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int W = 3,
  parameter logic [W-1:0] INIT = '0,
  parameter int BUSY_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int BW = $clog2(BUSY_TICKS + 1);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= INIT;
      active <= INIT;
      bcnt   <= '0;
    end else if (wr) begin
      shadow <= wdata;
      bcnt   <= BW'(BUSY_TICKS);
    end else if (tick && bcnt != '0) begin
      bcnt <= bcnt - 1'b1;
      if (bcnt == BW'(1)) active <= shadow;
    end
  end

  assign busy = (bcnt != '0);

  // R7: the value in force equals the written one once busy drops
  a_r7_apply_on_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (active == shadow));
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int CODE_W   = 3,
  parameter int BASE_LOG = 2,
  parameter int MAX_CODE = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              step
);
  localparam int CW = BASE_LOG + MAX_CODE;
  logic [CW-1:0] pcnt;
  logic [CW-1:0] lim;
  int unsigned   eff;

  always_comb begin
    eff = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
    lim = CW'((32'd1 << (BASE_LOG + eff)) - 32'd1);
  end

  assign step = run && tick && (pcnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)       pcnt <= '0;
    else if (run && tick) pcnt <= step ? '0 : pcnt + 1'b1;
  end

  // R6: a wrap always returns the phase to zero
  a_r6_wrap_phase: assert property (@(posedge clk) disable iff (rst)
    step |=> (pcnt == '0));
endmodule

// File: rtl/wdg_countdown.sv
module wdg_countdown #(
  parameter int RL_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  input  logic            load,
  input  logic [RL_W-1:0] reload,
  output logic            rst_req
);
  logic [RL_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (load) begin
        cnt <= reload;
      end else if (step) begin
        if (cnt == '0) begin
          rst_req <= 1'b1;
          cnt     <= reload;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R9: the request is a single-cycle pulse
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R11: a reload in the same cycle as a step suppresses the request
  a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
    load |=> !rst_req);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W     = 16,
  parameter int PR_W       = 3,
  parameter int RL_W       = 12,
  parameter int BUSY_TICKS = 2,
  parameter int BASE_LOG   = 2,
  parameter int MAX_CODE   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lsi_tick,
  input  logic              dbg_freeze,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              reset_req
);
  import wdg_pkg::*;

  logic unlocked, running;
  logic key_wr, load, pre_wr, rld_wr, count_en, step;
  logic [PR_W-1:0] pre_shadow, pre_active;
  logic [RL_W-1:0] rld_shadow, rld_active;
  logic pre_busy, rld_busy;

  assign key_wr   = bus_wr && (bus_addr == ADDR_KEY);
  assign load     = key_wr && (bus_wdata == DATA_W'(KEY_KICK) ||
                               bus_wdata == DATA_W'(KEY_RUN));
  assign pre_wr   = bus_wr && (bus_addr == ADDR_PRE) && unlocked;
  assign rld_wr   = bus_wr && (bus_addr == ADDR_RLD) && unlocked;
  assign count_en = running && !dbg_freeze;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      running  <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (bus_wdata == DATA_W'(KEY_UNLOCK));
      if (bus_wdata == DATA_W'(KEY_RUN)) running <= 1'b1;
    end
  end

  wdg_cfg_slot #(.W(PR_W), .INIT('0), .BUSY_TICKS(BUSY_TICKS)) u_pre (
    .clk(clk), .rst(rst), .tick(lsi_tick), .wr(pre_wr),
    .wdata(bus_wdata[PR_W-1:0]), .shadow(pre_shadow),
    .active(pre_active), .busy(pre_busy));

  wdg_cfg_slot #(.W(RL_W), .INIT('1), .BUSY_TICKS(BUSY_TICKS)) u_rld (
    .clk(clk), .rst(rst), .tick(lsi_tick), .wr(rld_wr),
    .wdata(bus_wdata[RL_W-1:0]), .shadow(rld_shadow),
    .active(rld_active), .busy(rld_busy));

  wdg_prescale #(.CODE_W(PR_W), .BASE_LOG(BASE_LOG), .MAX_CODE(MAX_CODE)) u_div (
    .clk(clk), .rst(rst), .tick(lsi_tick), .run(count_en), .clr(load),
    .code(pre_active), .step(step));

  wdg_countdown #(.RL_W(RL_W)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .load(load),
    .reload(rld_active), .rst_req(reset_req));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADDR_PRE:  bus_rdata <= DATA_W'(pre_shadow);
        ADDR_RLD:  bus_rdata <= DATA_W'(rld_shadow);
        ADDR_STAT: bus_rdata <= DATA_W'({rld_busy, pre_busy});
        default:   bus_rdata <= '0;
      endcase
    end
  end

  // R10: running never returns to idle without reset
  a_r10_sticky_run: assert property (@(posedge clk) disable iff (rst)
    running |=> running);
  // R8: freeze blocks every counter step
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    dbg_freeze |-> !step);
  // R4: locked writes leave the prescaler register untouched
  a_r4_locked_pre: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_PRE && !unlocked) |=> $stable(pre_shadow));
  // R1: an idle watchdog never requests a reset
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    reset_req |-> running);
endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lsi_tick = 1'b0, dbg_freeze = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic reset_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_watchdog dut (.clk(clk), .rst(rst), .lsi_tick(lsi_tick),
    .dbg_freeze(dbg_freeze), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .reset_req(reset_req));

  function automatic int timeout_of(int pr, int rl);
    int dv = (pr >= 6) ? 256 : (4 << pr);
    return (rl + 1) * dv;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = int'(bus_rdata);
  endtask

  task automatic tick1(output bit seen, output bit stay);
    lsi_tick = 1'b1;
    @(posedge clk); @(negedge clk);
    lsi_tick = 1'b0; seen = reset_req;
    @(posedge clk); @(negedge clk);
    stay = reset_req;
  endtask

  task automatic ticks(input int n, output int pulses);
    bit s, t;
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      tick1(s, t);
      pulses += int'(s) + int'(t);
    end
  endtask

  task automatic measure(input int lim, output int at, output int stay);
    bit s, t;
    at = 0; stay = 0;
    for (int i = 1; i <= lim; i++) begin
      tick1(s, t);
      if (s) begin at = i; stay = int'(t); break; end
    end
  endtask

  task automatic configure(input int pr, input int rl);
    bit s, t;
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(pr));
    wr(2'd2, 16'(rl));
    wr(2'd0, 16'hAAAA);
    tick1(s, t); tick1(s, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, at, st, p;
    bit s, t;
    void'($urandom(32'd1234));
    do_reset();
    // R1 / R12 reset state
    chk("R1 reset_req", int'(reset_req), 0);
    rd(2'd1, v); chk("R1 prescaler", v, 0);
    rd(2'd2, v); chk("R1 reload", v, 12'hFFF);
    rd(2'd3, v); chk("R1 status", v, 0);
    rd(2'd0, v); chk("R12 key reads zero", v, 0);
    // R4 locked write ignored
    wr(2'd1, 16'd5); rd(2'd1, v); chk("R4 locked prescaler", v, 0);
    wr(2'd2, 16'd7); rd(2'd2, v); chk("R4 locked reload", v, 12'hFFF);
    // R5 relock by other key
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234);
    wr(2'd1, 16'd5); rd(2'd1, v); chk("R5 relocked", v, 0);
    // R4 / R7 unlocked write and busy flags
    wr(2'd0, 16'h5555); wr(2'd1, 16'd0); wr(2'd2, 16'd2);
    rd(2'd2, v); chk("R4 reload accepted", v, 2);
    rd(2'd3, v); chk("R7 both busy", v, 3);
    tick1(s, t); rd(2'd3, v); chk("R7 busy after one tick", v, 3);
    tick1(s, t); rd(2'd3, v); chk("R7 busy cleared", v, 0);
    wr(2'd0, 16'hAAAA);
    // R1 idle ignores ticks
    ticks(40, p); chk("R1 idle no reset", p, 0);
    // R2 start and timeout, R9 pulse and restart
    wr(2'd0, 16'hCCCC);
    measure(100, at, st); chk("R2 timeout", at, timeout_of(0, 2));
    chk("R9 one cycle", st, 0);
    measure(100, at, st); chk("R9 restart period", at, 12);
    // R3 refresh
    ticks(10, p); chk("R3 before refresh", p, 0);
    wr(2'd0, 16'hAAAA);
    measure(100, at, st); chk("R3 full period after refresh", at, 12);
    // R11 refresh on the expiring tick
    ticks(11, p);
    lsi_tick = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 16'hAAAA;
    @(posedge clk); @(negedge clk);
    lsi_tick = 1'b0; bus_wr = 1'b0;
    chk("R11 no reset on coincidence", int'(reset_req), 0);
    measure(100, at, st); chk("R11 full period follows", at, 12);
    // R8 freeze
    ticks(5, p);
    dbg_freeze = 1'b1; ticks(50, p); chk("R8 frozen no reset", p, 0);
    dbg_freeze = 1'b0;
    measure(100, at, st); chk("R8 resumes remainder", at, 7);
    // R10 software cannot stop
    wr(2'd0, 16'h0000); wr(2'd0, 16'h5555); wr(2'd0, 16'h0001);
    measure(100, at, st); chk("R10 still running", at, 12);
    // R7 new reload takes effect only after busy clears
    wr(2'd0, 16'h5555); wr(2'd2, 16'd5); wr(2'd0, 16'hAAAA);
    measure(100, at, st); chk("R7 old value in force", at, 12);
    measure(100, at, st); chk("R7 new value after reload", at, 24);
    // R6 / R2 random configurations
    for (int k = 0; k < 6; k++) begin
      int pr, rl;
      pr = (k == 0) ? 7 : int'($urandom % 8);
      rl = int'($urandom % 6);
      do_reset();
      configure(pr, rl);
      rd(2'd1, v); chk("R4 prescaler readback", v, pr);
      wr(2'd0, 16'hCCCC);
      measure(3000, at, st); chk("R6 divider timeout", at, timeout_of(pr, rl));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule